// File: doc/BRIEF.md
# Rank-Based Ready Instruction Picker

The picker looks at a small pool of instructions that are ready to issue and names one of them each cycle. Every pool slot carries a valid bit, an age index in program order, a count of later instructions known to consume its result, and a mask of the execution units it needs. A slot can issue only when every unit it needs is free in that cycle. Among those slots the picker prefers the lowest rank, where rank is the age index minus the consumer count. Old instructions and instructions that many others wait on therefore go first.

The choice is combinational. It appears on `pick_valid` and `pick_slot` in the same cycle the pool and the free-unit vector are presented. A registered mask, `blocked_res`, records which execution units kept a valid slot from issuing during the previous cycle. It is rebuilt from scratch on every clock, so it never collects stale bits. The logic that fills the pool, wakes up operands or runs the chosen instruction sits outside the block.

Top module: `rank_pick`

## Requirements
- R1: The rank of slot s is the signed difference age(s) − cons(s), with no wraparound. An entry with age 0 and 15 consumers has rank −15 and beats any entry with a non-negative rank.
- R2: Among eligible slots, the one with the numerically lowest rank is picked.
- R3: When ranks are equal, the slot with the smaller age wins. When rank and age are both equal, the lower slot number wins.
- R4: Slot s is eligible when `ent_valid[s]` is 1 and every bit set in `ent_res[s*RES_W +: RES_W]` is also set in `res_free`. A 1 in `res_free` means that unit is free.
- R5: When no slot is eligible, `pick_valid` is 0 and `pick_slot` is 0.
- R6: `pick_valid` and `pick_slot` follow the inputs in the same cycle, with no register delay.
- R7: One clock after a cycle, `blocked_res` equals the OR, over all valid slots, of each slot's required units that are not free in that cycle.
- R8: `blocked_res` is recomputed every cycle and keeps nothing from older cycles. A cycle with no blocked slot gives all zeros on the next clock.
- R9: While `rst` is high at a clock edge, `blocked_res` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | ENTRIES | Slot holds a ready instruction |
| ent_age | input | ENTRIES*AGE_W | Program-order age index per slot, slot s at [s*AGE_W +: AGE_W] |
| ent_cons | input | ENTRIES*CONS_W | Known consumer count per slot |
| ent_res | input | ENTRIES*RES_W | Required execution units per slot |
| res_free | input | RES_W | Execution units free this cycle |
| pick_valid | output | 1 | A slot was chosen |
| pick_slot | output | clog2(ENTRIES) | Index of the chosen slot |
| blocked_res | output | RES_W | Units that blocked a valid slot in the previous cycle |

## Verification
Directed pools separate the ranking rules one at a time:
- An older entry against a younger one with many consumers shows that rank, not age alone, decides.
- Equal-rank pairs placed in both slot orders show the tie-break.
- A large consumer count on a tiny age makes a negative rank, which exposes unsigned or truncated arithmetic.

Pools where the best slot is short of a unit show that the picker falls through to the next eligible slot. The same pools show that `blocked_res` lists exactly the missing units and drops them one cycle after they become free. Long random runs with narrow age ranges produce many ties and partial resource conflicts. Each cycle is compared with a behavioural model.

// File: rtl/rank_pick_pkg.sv
`timescale 1ns/1ps
package rank_pick_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_AGE_W   = 8;
  localparam int unsigned DEF_CONS_W  = 4;
  localparam int unsigned DEF_RES_W   = 8;

  // Width of a slot index; at least one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // True when the right contender beats the left one. Left wins on a full tie,
  // and left always carries the lower slot numbers.
  function automatic logic take_right(input logic lv, input int lr, input int la,
                                      input logic rv, input int rr, input int ra);
    return rv && (!lv || (rr < lr) || ((rr == lr) && (ra < la)));
  endfunction
endpackage

// File: rtl/rank_pick_score.sv
`timescale 1ns/1ps
module rank_pick_score #(
  parameter int unsigned N   = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned CW  = 4,
  parameter int unsigned RW  = 8,
  parameter int unsigned RKW = 9
) (
  input  logic [N-1:0]          vld,
  input  logic [N*AW-1:0]       age_flat,
  input  logic [N*CW-1:0]       cons_flat,
  input  logic [N*RW-1:0]       res_flat,
  input  logic [RW-1:0]         free,
  output logic [N-1:0]          elig,
  output logic signed [RKW-1:0] rank [N],
  output logic [AW-1:0]         age  [N]
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [AW-1:0] a;
    logic [CW-1:0] c;
    logic [RW-1:0] r;
    assign a = age_flat[i*AW +: AW];
    assign c = cons_flat[i*CW +: CW];
    assign r = res_flat[i*RW +: RW];
    assign rank[i] = $signed({{(RKW-AW){1'b0}}, a}) - $signed({{(RKW-CW){1'b0}}, c});
    assign elig[i] = vld[i] && ((r & ~free) == '0);
    assign age[i]  = a;
  end
endmodule

// File: rtl/rank_pick_tree.sv
`timescale 1ns/1ps
module rank_pick_tree
  import rank_pick_pkg::*;
#(
  parameter int unsigned N   = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned RKW = 9,
  parameter int unsigned IW  = 3
) (
  input  logic [N-1:0]          elig,
  input  logic signed [RKW-1:0] rank [N],
  input  logic [AW-1:0]         age  [N],
  output logic                  win_v,
  output logic [IW-1:0]         win_idx
);
  localparam int unsigned LVL = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned NP  = 1 << LVL;

  logic                  nv [LVL+1][NP];
  logic signed [RKW-1:0] nr [LVL+1][NP];
  logic [AW-1:0]         na [LVL+1][NP];
  logic [IW-1:0]         ni [LVL+1][NP];

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int unsigned W = NP >> l;
    for (genvar k = 0; k < NP; k++) begin : g_node
      if (k >= W) begin : g_pad
        assign nv[l][k] = 1'b0;
        assign nr[l][k] = '0;
        assign na[l][k] = '0;
        assign ni[l][k] = '0;
      end else if (l == 0) begin : g_leaf
        if (k < N) begin : g_real
          assign nv[l][k] = elig[k];
          assign nr[l][k] = rank[k];
          assign na[l][k] = age[k];
          assign ni[l][k] = IW'(k);
        end else begin : g_empty
          assign nv[l][k] = 1'b0;
          assign nr[l][k] = '0;
          assign na[l][k] = '0;
          assign ni[l][k] = '0;
        end
      end else begin : g_merge
        logic rt;
        assign rt = take_right(nv[l-1][2*k],   int'(nr[l-1][2*k]),   int'(na[l-1][2*k]),
                               nv[l-1][2*k+1], int'(nr[l-1][2*k+1]), int'(na[l-1][2*k+1]));
        assign nv[l][k] = rt ? nv[l-1][2*k+1] : nv[l-1][2*k];
        assign nr[l][k] = rt ? nr[l-1][2*k+1] : nr[l-1][2*k];
        assign na[l][k] = rt ? na[l-1][2*k+1] : na[l-1][2*k];
        assign ni[l][k] = rt ? ni[l-1][2*k+1] : ni[l-1][2*k];
      end
    end
  end

  assign win_v   = nv[LVL][0];
  assign win_idx = ni[LVL][0];
endmodule

// File: rtl/rank_pick_blocked.sv
`timescale 1ns/1ps
module rank_pick_blocked #(
  parameter int unsigned N  = 8,
  parameter int unsigned RW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      vld,
  input  logic [N*RW-1:0]   res_flat,
  input  logic [RW-1:0]     free,
  output logic [RW-1:0]     blk_q
);
  logic [RW-1:0] blk_d;

  always_comb begin
    blk_d = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i]) blk_d = blk_d | (res_flat[i*RW +: RW] & ~free);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) blk_q <= '0;
    else     blk_q <= blk_d;
  end
endmodule

// File: rtl/rank_pick.sv
`timescale 1ns/1ps
module rank_pick
  import rank_pick_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned AGE_W   = DEF_AGE_W,
  parameter int unsigned CONS_W  = DEF_CONS_W,
  parameter int unsigned RES_W   = DEF_RES_W,
  localparam int unsigned IDX_W  = idx_width(ENTRIES),
  localparam int unsigned RANK_W = ((AGE_W > CONS_W) ? AGE_W : CONS_W) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ENTRIES-1:0]        ent_valid,
  input  logic [ENTRIES*AGE_W-1:0]  ent_age,
  input  logic [ENTRIES*CONS_W-1:0] ent_cons,
  input  logic [ENTRIES*RES_W-1:0]  ent_res,
  input  logic [RES_W-1:0]          res_free,
  output logic                      pick_valid,
  output logic [IDX_W-1:0]          pick_slot,
  output logic [RES_W-1:0]          blocked_res
);
  logic [ENTRIES-1:0]        elig;
  logic signed [RANK_W-1:0]  rank [ENTRIES];
  logic [AGE_W-1:0]          age  [ENTRIES];
  logic                      win_v;
  logic [IDX_W-1:0]          win_idx;

  rank_pick_score #(.N(ENTRIES), .AW(AGE_W), .CW(CONS_W), .RW(RES_W), .RKW(RANK_W)) u_score (
    .vld(ent_valid), .age_flat(ent_age), .cons_flat(ent_cons), .res_flat(ent_res),
    .free(res_free), .elig(elig), .rank(rank), .age(age)
  );

  rank_pick_tree #(.N(ENTRIES), .AW(AGE_W), .RKW(RANK_W), .IW(IDX_W)) u_tree (
    .elig(elig), .rank(rank), .age(age), .win_v(win_v), .win_idx(win_idx)
  );

  rank_pick_blocked #(.N(ENTRIES), .RW(RES_W)) u_blk (
    .clk(clk), .rst(rst), .vld(ent_valid), .res_flat(ent_res), .free(res_free),
    .blk_q(blocked_res)
  );

  assign pick_valid = win_v;
  assign pick_slot  = win_v ? win_idx : '0;
endmodule

// File: rtl/rank_pick_chk.sv
`timescale 1ns/1ps
module rank_pick_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 4,
  parameter int unsigned RW = 8,
  parameter int unsigned IW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    ent_valid,
  input logic [N*AW-1:0] ent_age,
  input logic [N*CW-1:0] ent_cons,
  input logic [N*RW-1:0] ent_res,
  input logic [RW-1:0]   res_free,
  input logic            pick_valid,
  input logic [IW-1:0]   pick_slot,
  input logic [RW-1:0]   blocked_res
);
  logic [N-1:0] ok;
  int           rk [N];
  int           ag [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ok[i] = ent_valid[i] && ((ent_res[i*RW +: RW] & res_free) == ent_res[i*RW +: RW]);
      ag[i] = int'(ent_age[i*AW +: AW]);
      rk[i] = ag[i] - int'(ent_cons[i*CW +: CW]);
    end
  end

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> ok[pick_slot]) else $error("picked slot not eligible"); // R4

  AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
    !pick_valid |-> (ok == '0 && pick_slot == '0)) else $error("idle with eligible slot"); // R5

  for (genvar i = 0; i < N; i++) begin : g_best
    AST_PICK_BEST: assert property (@(posedge clk) disable iff (rst)
      (pick_valid && ok[i]) |-> (rk[pick_slot] < rk[i] ||
        (rk[pick_slot] == rk[i] && ag[pick_slot] <= ag[i]))) else $error("better slot skipped"); // R2
  end

  AST_BLOCKED_UNAVAIL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((blocked_res & $past(res_free)) == '0)) else $error("free unit reported blocked"); // R7

  AST_BLOCKED_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (ent_valid == '0) |=> (blocked_res == '0)) else $error("stale blocked bits"); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (blocked_res == '0)) else $error("blocked mask not cleared by reset"); // R9
endmodule

bind rank_pick rank_pick_chk #(
  .N(ENTRIES), .AW(AGE_W), .CW(CONS_W), .RW(RES_W), .IW(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_age(ent_age), .ent_cons(ent_cons),
  .ent_res(ent_res), .res_free(res_free), .pick_valid(pick_valid), .pick_slot(pick_slot),
  .blocked_res(blocked_res)
);

// File: tb/rank_pick_bench.sv
`timescale 1ns/1ps
module rank_pick_bench;
  localparam int N = 8, AW = 8, CW = 4, RW = 8, IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]    ent_valid;
  logic [N*AW-1:0] ent_age;
  logic [N*CW-1:0] ent_cons;
  logic [N*RW-1:0] ent_res;
  logic [RW-1:0]   res_free;
  logic            pick_valid;
  logic [IW-1:0]   pick_slot;
  logic [RW-1:0]   blocked_res;

  // Applied pool (t_) and staging pool (s_) written by the scenarios.
  logic [N-1:0]  t_v, s_v;
  logic [AW-1:0] t_age [N], s_age [N];
  logic [CW-1:0] t_cons [N], s_cons [N];
  logic [RW-1:0] t_res [N], s_res [N];
  logic [RW-1:0] t_free, s_free;

  always_comb begin
    ent_valid = t_v;
    res_free  = t_free;
    for (int i = 0; i < N; i++) begin
      ent_age[i*AW +: AW]  = t_age[i];
      ent_cons[i*CW +: CW] = t_cons[i];
      ent_res[i*RW +: RW]  = t_res[i];
    end
  end

  rank_pick u_rank_pick (
    .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_age(ent_age), .ent_cons(ent_cons),
    .ent_res(ent_res), .res_free(res_free), .pick_valid(pick_valid), .pick_slot(pick_slot),
    .blocked_res(blocked_res)
  );

  int checks = 0;
  int errors = 0;
  logic [RW-1:0] exp_blk = '0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_stage();
    s_v = '0;
    s_free = '1;
    for (int i = 0; i < N; i++) begin
      s_age[i] = '0; s_cons[i] = '0; s_res[i] = '0;
    end
  endtask

  task automatic put(input int s, input int a, input int c, input int r);
    s_v[s] = 1'b1;
    s_age[s] = a[AW-1:0];
    s_cons[s] = c[CW-1:0];
    s_res[s] = r[RW-1:0];
  endtask

  task automatic apply_stage();
    t_v = s_v; t_free = s_free;
    for (int i = 0; i < N; i++) begin
      t_age[i] = s_age[i]; t_cons[i] = s_cons[i]; t_res[i] = s_res[i];
    end
  endtask

  // One cycle: check last cycle's blocked mask, apply the staged pool, check the pick.
  task automatic run_cycle(input string tag, input string btag);
    int bi, br, ba, r, a;
    logic [RW-1:0] nb;
    @(negedge clk);
    chk(btag, "blocked_res", int'(blocked_res), int'(exp_blk));
    apply_stage();
    #1;
    bi = -1; br = 0; ba = 0; nb = '0;
    for (int i = 0; i < N; i++) begin
      if (t_v[i]) nb = nb | (t_res[i] & ~t_free);
      if (t_v[i] && ((t_res[i] & ~t_free) == '0)) begin
        r = int'(t_age[i]) - int'(t_cons[i]);
        a = int'(t_age[i]);
        if (bi < 0 || r < br || (r == br && a < ba)) begin
          bi = i; br = r; ba = a;
        end
      end
    end
    chk(tag, "pick_valid (R6 same cycle)", int'(pick_valid), (bi >= 0) ? 1 : 0);
    chk(tag, "pick_slot", int'(pick_slot), (bi >= 0) ? bi : 0);
    exp_blk = nb;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset with a blocking pool on the inputs.
    clear_stage();
    put(0, 5, 0, 'h0F);
    s_free = 8'hF0;
    apply_stage();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "blocked_res in reset", int'(blocked_res), 0);
    clear_stage();
    apply_stage();
    rst = 1'b0;
    exp_blk = '0;

    // Empty pool.
    clear_stage();
    run_cycle("R5", "R8");

    // Single entry.
    put(3, 40, 1, 'h01);
    run_cycle("R2", "R7");

    // Younger entry with many consumers beats older one.
    clear_stage();
    put(0, 10, 0, 0); put(5, 12, 5, 0);
    run_cycle("R2", "R7");

    // Equal rank, older in higher slot.
    clear_stage();
    put(1, 20, 4, 0); put(6, 18, 2, 0);
    run_cycle("R3", "R7");

    // Equal rank and age: lower slot.
    clear_stage();
    put(2, 30, 3, 0); put(7, 30, 3, 0);
    run_cycle("R3", "R7");

    // Negative rank beats zero rank.
    clear_stage();
    put(0, 0, 0, 0); put(4, 0, 15, 0); put(6, 3, 15, 0);
    run_cycle("R1", "R7");

    // Age extremes.
    clear_stage();
    put(1, 255, 0, 0); put(2, 254, 0, 0); put(3, 255, 15, 0);
    run_cycle("R1", "R7");

    // Best entry short of a unit; next best is picked.
    clear_stage();
    put(0, 2, 0, 'h04); put(1, 9, 0, 'h01); put(2, 50, 0, 'h10);
    s_free = 8'hFB;
    run_cycle("R4", "R7");

    // Every valid entry blocked.
    clear_stage();
    put(0, 2, 0, 'h03); put(5, 7, 1, 'h80); put(6, 1, 0, 'h10);
    s_free = 8'h6C;
    run_cycle("R5", "R7");

    // Same pool, all free: blocked mask from previous cycle must show units.
    s_free = '1;
    run_cycle("R4", "R7");

    // Next cycle: nothing blocked last cycle, mask back to zero.
    run_cycle("R2", "R8");
    clear_stage();
    run_cycle("R5", "R8");

    // Random pools; narrow ranges in half the runs to force ties.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      clear_stage();
      for (int i = 0; i < N; i++) begin
        rv = $urandom;
        if (rv[1:0] != 2'b00) begin
          s_v[i]    = 1'b1;
          s_age[i]  = (n % 2 == 0) ? {4'h0, rv[11:8]} : rv[15:8];
          s_cons[i] = rv[19:16];
          s_res[i]  = rv[27:20] & rv[31:24] & rv[23:16];
        end
      end
      rv = $urandom;
      s_free = rv[7:0] | rv[15:8];
      run_cycle("R1,R2,R3,R4", "R7");
    end

    run_cycle("R2", "R7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule